// File: doc/BRIEF.md
# Interrupt Redirection and Destination Resolver

This block turns rising edges on a set of interrupt pins into interrupt messages addressed to a group of local interrupt controllers. Each pin has a routing entry, supplied as a flat input vector. When a pin goes from low to high, the block latches the edge. It then looks up the routing entry for that pin. If the entry is not masked, the block builds a message that carries:
- the vector;
- the delivery mode;
- the destination mode;
- the level bit;
- the trigger bit.

It also builds a target mask with one bit per local controller. Controller `i` has the identifier `i`. Only controllers with an index below `active_cnt` can be targeted.

In physical destination mode the destination byte selects either one controller or, when it is all ones, every active controller. In logical destination mode the destination byte is compared with each controller's logical-destination byte, and every controller that shares at least one set bit with it is targeted. Lowest-priority delivery in logical mode does not read any controller priority. Instead it rotates a persistent counter over the matched controllers and sends to exactly one of them. Lowest-priority delivery in physical mode is illegal: the block raises a one-cycle error pulse and sends nothing.

The message leaves through a valid/ready port. Once `msg_valid` is high, the message and its target mask stay fixed until the cycle in which `msg_ready` is high. Edges that arrive while the port is stalled stay latched. No further pin is served until the output slot frees, so back-pressure never loses an edge.

Top module: `irq_redirector`

## Requirements
- R1: After reset, `msg_valid` and `lp_error` are low, no edge is pending, and the rotation counter is zero.
- R2: A pin produces a message only on a low-to-high transition. A pin held high produces no further message until it has been lowered and raised again.
- R3: A routing entry with its mask bit (bit 14) set produces no message and no error.
- R4: With delivery mode 3'b111 (external) the message vector is `ext_vector`. For every other mode it is the entry's vector field (bits 7:0). The delivery mode sits in bits 10:8.
- R5: In physical mode (bit 11 clear), destination 8'hFF (bits 22:15) targets every controller with an index below `active_cnt`.
- R6: In physical mode, any other destination targets only the controller whose index equals it. If no active controller has that index, the target mask is empty.
- R7: Delivery mode 3'b001 (lowest priority) in physical mode pulses `lp_error` for one cycle and sends no message.
- R8: In logical mode (bit 11 set), an active controller is targeted when its byte in `ldest_tbl` ANDed with the destination byte is nonzero.
- R9: For logical lowest-priority delivery with M > 0 matches, the single target is the k-th matched controller in ascending index order, where k = counter mod M. The counter then increments by one.
- R10: For a logical message with no match, the block still sends a message, with an empty target mask. In lowest-priority mode the counter stays unchanged.
- R11: `msg_level` copies the polarity bit (bit 12), `msg_trigger` copies the trigger bit (bit 13), and `msg_dmode` and `msg_logical` copy the entry's delivery mode and destination mode.
- R12: Pins that rise together are served one per free output slot, lowest pin index first. Each pending edge stays latched until it is served.
- R13: While `msg_valid` is high and `msg_ready` is low, every message output holds its value and no other pin is served. When `msg_valid` and `msg_ready` are both high, the next pending pin may load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS | Interrupt pin levels |
| route_tbl | input | NPINS*23 | Routing entries, entry p at bits [p*23 +: 23] |
| ldest_tbl | input | NCPU*8 | Logical-destination byte of each controller, controller c at [c*8 +: 8] |
| ext_vector | input | 8 | Vector supplied by the external controller |
| active_cnt | input | $clog2(NCPU+1) | Number of active controllers (indices 0 to active_cnt-1) |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dmode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Message destination mode, 1 = logical |
| msg_level | output | 1 | Message level bit |
| msg_trigger | output | 1 | Message trigger bit |
| msg_targets | output | NCPU | Target controller mask |
| lp_error | output | 1 | One-cycle pulse for illegal physical lowest-priority delivery |

## Verification
The main function is exercised with a table of single-pin events that cover the following cases:
- physical unicast, broadcast and an out-of-range destination, which separate the three physical decoding paths;
- a masked entry and an external-mode entry, which show whether the mask and the vector source are honoured;
- a physical lowest-priority entry, which must raise the error with no message.

A sequence of logical lowest-priority events over two different match sets shows whether the modulo uses the match count and whether the counter advances. One of these events has no match, and the event that follows it reveals whether that empty event disturbed the counter. Directed cases add the following:
- two pins raised together under a stalled consumer, which separates pin ordering from hold behaviour;
- a held-high pin, which checks that it is not re-armed;
- a reduced `active_cnt` during broadcast, which excludes the inactive controllers;
- level and trigger bits, which check that both are copied into the message.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int DM_W   = 3;
  localparam int ENT_W  = VEC_W + DM_W + 4 + DEST_W;

  localparam logic [DM_W-1:0] DM_FIXED  = 3'b000;
  localparam logic [DM_W-1:0] DM_LOWPRI = 3'b001;
  localparam logic [DM_W-1:0] DM_EXTINT = 3'b111;

  localparam logic [DEST_W-1:0] DEST_ALL = '1;

  // packed from MSB to LSB: dest, mask, trig, pol, logical, dmode, vector
  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trig;
    logic              pol;
    logic              logical;
    logic [DM_W-1:0]   dmode;
    logic [VEC_W-1:0]  vector;
  } route_ent_t;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] pending
);
  logic [NPINS-1:0] pin_q;
  logic [NPINS-1:0] rise;

  assign rise = pin_in & ~pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q   <= '0;
      pending <= '0;
    end else begin
      pin_q   <= pin_in;
      pending <= (pending & ~clr) | rise;
    end
  end

  // R12
  clr_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~pending) == '0) && $onehot0(clr));
endmodule

// File: rtl/irq_pick_lowest.sv
module irq_pick_lowest #(
  parameter int N     = 8,
  localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt = '0;
        gnt[i] = 1'b1;
        idx = IW'(i);
      end
    end
    any = |req;
  end
endmodule

// File: rtl/irq_msg_resolve.sv
module irq_msg_resolve
  import irq_route_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int LPC_W = 8,
  localparam int CW   = $clog2(NCPU + 1)
) (
  input  logic [VEC_W-1:0]       ent_vector,
  input  logic [DM_W-1:0]        ent_dmode,
  input  logic                   ent_logical,
  input  logic [DEST_W-1:0]      ent_dest,
  input  logic [NCPU*DEST_W-1:0] ldest_tbl,
  input  logic [VEC_W-1:0]       ext_vector,
  input  logic [CW-1:0]          active_cnt,
  input  logic [LPC_W-1:0]       lp_count,
  output logic [VEC_W-1:0]       out_vector,
  output logic [NCPU-1:0]        targets,
  output logic                   bad_mode,
  output logic                   lp_hit
);
  logic [NCPU-1:0]  act;
  logic [NCPU-1:0]  phys_t;
  logic [NCPU-1:0]  log_t;
  logic [NCPU-1:0]  lp_t;
  logic [CW-1:0]    mcount;
  logic [LPC_W-1:0] k;
  logic             is_lp;

  assign is_lp      = (ent_dmode == DM_LOWPRI);
  assign out_vector = (ent_dmode == DM_EXTINT) ? ext_vector : ent_vector;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign act[c]    = (int'(active_cnt) > c);
    assign phys_t[c] = act[c] &
                       ((ent_dest == DEST_ALL) || (ent_dest == DEST_W'(c)));
    assign log_t[c]  = act[c] & (|(ldest_tbl[c*DEST_W +: DEST_W] & ent_dest));
  end

  always_comb begin
    mcount = '0;
    for (int c = 0; c < NCPU; c++) mcount = mcount + CW'(log_t[c]);
  end

  assign k = (mcount != '0) ? (lp_count % LPC_W'(mcount)) : '0;

  always_comb begin
    logic [CW-1:0] seen;
    seen = '0;
    lp_t = '0;
    for (int c = 0; c < NCPU; c++) begin
      if (log_t[c]) begin
        if (LPC_W'(seen) == k) lp_t[c] = 1'b1;
        seen = seen + 1'b1;
      end
    end
  end

  assign bad_mode = is_lp & ~ent_logical;
  assign lp_hit   = is_lp & ent_logical & (mcount != '0);
  assign targets  = !ent_logical ? phys_t : (is_lp ? lp_t : log_t);
endmodule

// File: rtl/irq_redirector.sv
module irq_redirector
  import irq_route_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int NCPU  = 4,
  parameter int LPC_W = 8,
  localparam int CW   = $clog2(NCPU + 1),
  localparam int IW   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       pin_in,
  input  logic [NPINS*ENT_W-1:0] route_tbl,
  input  logic [NCPU*DEST_W-1:0] ldest_tbl,
  input  logic [VEC_W-1:0]       ext_vector,
  input  logic [CW-1:0]          active_cnt,
  output logic                   msg_valid,
  input  logic                   msg_ready,
  output logic [VEC_W-1:0]       msg_vector,
  output logic [DM_W-1:0]        msg_dmode,
  output logic                   msg_logical,
  output logic                   msg_level,
  output logic                   msg_trigger,
  output logic [NCPU-1:0]        msg_targets,
  output logic                   lp_error
);
  logic [NPINS-1:0] pending;
  logic [NPINS-1:0] gnt;
  logic [NPINS-1:0] clr;
  logic [IW-1:0]    sel_idx;
  logic             any_pend;
  logic             slot_free;
  logic             serve;
  logic             load;
  route_ent_t       ent;
  logic [VEC_W-1:0] r_vector;
  logic [NCPU-1:0]  r_targets;
  logic             r_bad;
  logic             r_lp_hit;
  logic [LPC_W-1:0] lp_count;

  irq_edge_latch #(.NPINS(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .clr(clr), .pending(pending)
  );

  irq_pick_lowest #(.N(NPINS)) u_pick (
    .req(pending), .gnt(gnt), .idx(sel_idx), .any(any_pend)
  );

  assign ent = route_ent_t'(route_tbl[int'(sel_idx)*ENT_W +: ENT_W]);

  irq_msg_resolve #(.NCPU(NCPU), .LPC_W(LPC_W)) u_resolve (
    .ent_vector(ent.vector), .ent_dmode(ent.dmode), .ent_logical(ent.logical),
    .ent_dest(ent.dest), .ldest_tbl(ldest_tbl), .ext_vector(ext_vector),
    .active_cnt(active_cnt), .lp_count(lp_count), .out_vector(r_vector),
    .targets(r_targets), .bad_mode(r_bad), .lp_hit(r_lp_hit)
  );

  assign slot_free = ~msg_valid | msg_ready;
  assign serve     = slot_free & any_pend;
  assign clr       = serve ? gnt : '0;
  assign load      = serve & ~ent.mask & ~r_bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid   <= 1'b0;
      msg_vector  <= '0;
      msg_dmode   <= '0;
      msg_logical <= 1'b0;
      msg_level   <= 1'b0;
      msg_trigger <= 1'b0;
      msg_targets <= '0;
      lp_error    <= 1'b0;
      lp_count    <= '0;
    end else begin
      lp_error <= serve & ~ent.mask & r_bad;
      if (load) begin
        msg_valid   <= 1'b1;
        msg_vector  <= r_vector;
        msg_dmode   <= ent.dmode;
        msg_logical <= ent.logical;
        msg_level   <= ent.pol;
        msg_trigger <= ent.trig;
        msg_targets <= r_targets;
        if (r_lp_hit) lp_count <= lp_count + 1'b1;
      end else if (msg_ready) begin
        msg_valid <= 1'b0;
      end
    end
  end

  // R13
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector) &&
    $stable(msg_targets) && $stable(msg_dmode) && $stable(msg_logical));

  // R9
  lp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_logical && (msg_dmode == DM_LOWPRI) |-> $onehot0(msg_targets));

  // R7
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_error |-> !msg_valid);

  // R9
  lpc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && (lp_count != $past(lp_count)) |->
    lp_count == $past(lp_count) + 1'b1);
endmodule

// File: tb/irq_redirector_tb.sv
`timescale 1ns/1ps
module irq_redirector_tb_top;
  localparam int NPINS = 8;
  localparam int NCPU  = 4;
  localparam int EW    = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NPINS-1:0] pin_in = '0;
  logic [NPINS*EW-1:0] route_tbl = '0;
  logic [NCPU*8-1:0] ldest_tbl = {8'h08, 8'h05, 8'h02, 8'h01};
  logic [7:0] ext_vector = 8'h5A;
  logic [2:0] active_cnt = 3'd4;
  logic msg_valid, msg_ready = 1'b0;
  logic [7:0] msg_vector;
  logic [2:0] msg_dmode;
  logic msg_logical, msg_level, msg_trigger, lp_error;
  logic [NCPU-1:0] msg_targets;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_redirector #(.NPINS(NPINS), .NCPU(NCPU), .LPC_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .route_tbl(route_tbl),
    .ldest_tbl(ldest_tbl), .ext_vector(ext_vector), .active_cnt(active_cnt),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_dmode(msg_dmode), .msg_logical(msg_logical), .msg_level(msg_level),
    .msg_trigger(msg_trigger), .msg_targets(msg_targets), .lp_error(lp_error)
  );

  function automatic logic [EW-1:0] mk(logic [7:0] vec, logic [2:0] dm, logic lg,
                                       logic pol, logic trg, logic msk, logic [7:0] dst);
    return {dst, msk, trg, pol, lg, dm, vec};
  endfunction

  // row: pin[39:37] entry[36:14] valid[13] vector[12:5] targets[4:1] err[0]
  localparam int NROW = 13;
  localparam logic [39:0] TBL [NROW] = '{
    {3'd0, mk(8'h31, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02), 1'b1, 8'h31, 4'b0100, 1'b0}, // R6
    {3'd1, mk(8'h32, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF), 1'b1, 8'h32, 4'b1111, 1'b0}, // R5
    {3'd2, mk(8'h33, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01), 1'b0, 8'h00, 4'b0000, 1'b0}, // R3
    {3'd3, mk(8'h34, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01), 1'b1, 8'h5A, 4'b0010, 1'b0}, // R4
    {3'd4, mk(8'h35, 3'b001, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01), 1'b0, 8'h00, 4'b0000, 1'b1}, // R7
    {3'd5, mk(8'h36, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01), 1'b1, 8'h36, 4'b0101, 1'b0}, // R8
    {3'd6, mk(8'h37, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01), 1'b1, 8'h37, 4'b0001, 1'b0}, // R9
    {3'd6, mk(8'h37, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01), 1'b1, 8'h37, 4'b0100, 1'b0}, // R9
    {3'd7, mk(8'h38, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0E), 1'b1, 8'h38, 4'b1000, 1'b0}, // R9
    {3'd7, mk(8'h38, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 8'h0E), 1'b1, 8'h38, 4'b0010, 1'b0}, // R9
    {3'd5, mk(8'h39, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 8'h10), 1'b1, 8'h39, 4'b0000, 1'b0}, // R10
    {3'd6, mk(8'h3A, 3'b001, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01), 1'b1, 8'h3A, 4'b0001, 1'b0}, // R10
    {3'd2, mk(8'h3B, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h07), 1'b1, 8'h3B, 4'b0000, 1'b0}  // R6
  };

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ent(int p, logic [EW-1:0] e);
    route_tbl[p*EW +: EW] = e;
  endtask

  task automatic consume();
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(msg_valid == 1'b0 && lp_error == 1'b0, "R1", {msg_valid, lp_error}, 0);

    for (int r = 0; r < NROW; r++) begin
      int p;
      p = int'(TBL[r][39:37]);
      set_ent(p, TBL[r][36:14]);
      pin_in[p] = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(msg_valid == TBL[r][13], $sformatf("R2 row%0d valid", r), msg_valid, TBL[r][13]);
      check(lp_error == TBL[r][0], $sformatf("R7 row%0d err", r), lp_error, TBL[r][0]);
      if (TBL[r][13]) begin
        check(msg_vector == TBL[r][12:5], $sformatf("R4 row%0d vector", r), msg_vector, TBL[r][12:5]);
        check(msg_targets == TBL[r][4:1], $sformatf("R5 R6 R8 R9 R10 row%0d targets", r),
              msg_targets, TBL[r][4:1]);
        consume();
      end
      pin_in[p] = 1'b0;
      @(negedge clk);
    end

    // R11 field copies
    set_ent(3, mk(8'h44, 3'b000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h02));
    pin_in[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    check(msg_valid && msg_level && msg_trigger && msg_logical && msg_dmode == 3'b000,
          "R11", {msg_level, msg_trigger, msg_logical, msg_dmode}, 6'b111000);
    consume();
    // R2 held high: no re-trigger
    repeat (4) @(negedge clk);
    check(msg_valid == 1'b0, "R2 held", msg_valid, 0);
    pin_in[3] = 1'b0;
    @(negedge clk);
    pin_in[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    check(msg_valid == 1'b1, "R2 rearm", msg_valid, 1);
    consume();
    pin_in[3] = 1'b0;
    @(negedge clk);

    // R12 / R13 simultaneous rises under stall
    set_ent(1, mk(8'h41, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00));
    set_ent(4, mk(8'h43, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01));
    pin_in[1] = 1'b1;
    pin_in[4] = 1'b1;
    @(negedge clk); @(negedge clk);
    check(msg_valid && msg_vector == 8'h41, "R12 first", msg_vector, 8'h41);
    repeat (3) @(negedge clk);
    check(msg_valid && msg_vector == 8'h41 && msg_targets == 4'b0001, "R13 hold",
          msg_vector, 8'h41);
    consume();
    check(msg_valid && msg_vector == 8'h43 && msg_targets == 4'b0010, "R12 second",
          msg_vector, 8'h43);
    consume();
    check(msg_valid == 1'b0, "R13 drained", msg_valid, 0);
    pin_in = '0;
    @(negedge clk);

    // R5 with fewer active controllers
    active_cnt = 3'd2;
    set_ent(0, mk(8'h50, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF));
    pin_in[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    check(msg_valid && msg_targets == 4'b0011, "R5 active", msg_targets, 4'b0011);
    consume();
    pin_in[0] = 1'b0;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule